// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 interrupt request inputs and hands the CPU one request at a time: the most urgent one that is pending and enabled. Each line carries its own settings, written through a small configuration port: an enable bit, a 3-bit priority, a trigger mode (level or pulse) and a 32-bit vector address. The request that wins arbitration is shown to the CPU as a valid flag, a line number and the vector address. The CPU jumps straight to that address.

The CPU accepts a presented request with an acknowledge strobe and signals the end of a handler with a return strobe. The block keeps the running priority level and a stack of the levels it interrupted. A request that is strictly more urgent than the running handler is presented at once, so handlers nest. When a handler returns, arbitration uses the restored level in the same cycle. A request that is waiting is therefore presented immediately after the return, with no pass through the base level in between (tail chaining). Stack push and pop timing and the CPU itself lie outside the block.

Top module: `pvic_top`

## Requirements
- R1: Synchronous reset, active high. After reset, req_valid is 0, req_line is 0, req_vector is 0 and cur_level is 8 (idle). Every line is disabled, level-triggered, at priority 0, with vector 0.
- R2: A configuration write is taken on a clock edge when cfg_we is 1, for line cfg_line. The field is chosen by cfg_field: 0 writes the enable from cfg_data bit 0; 1 writes the priority from cfg_data[2:0]; 2 writes the mode from cfg_data bit 0 (1 = pulse, 0 = level); 3 writes the whole 32-bit vector. A new setting first affects the outputs two clock edges after the write cycle.
- R3: Arbitration considers every line that is pending, enabled, and whose priority value is numerically below cur_level. The lowest priority value wins. Between equal values, the lower line number wins. The winner appears on req_valid, req_line and req_vector (that line's vector) one clock edge after the inputs that caused it.
- R4: A disabled line is never presented, whatever its input or priority.
- R5: A level-mode line is pending only while its input is 1. If the input drops before acknowledge, the request is withdrawn at the next edge.
- R6: A pulse-mode line becomes pending on a 0-to-1 transition of its input, and stays pending after the input falls. Its pending state is cleared when that line's request is acknowledged. A rising transition in the acknowledge cycle or later sets it again.
- R7: When cpu_ack is 1 while req_valid is 1, the next edge saves the current level, sets cur_level to the presented line's priority and drives req_valid to 0 for one cycle. cpu_ack while req_valid is 0 is ignored.
- R8: While a handler runs, only a request with a priority value strictly below cur_level is presented. Requests of equal or larger value wait.
- R9: cpu_ret restores the level saved by the most recent acknowledge, in last-in-first-out order. cpu_ret is ignored when no handler is active (cur_level 8). If cpu_ack and cpu_ret are both asserted in a cycle where the acknowledge takes effect, the return is ignored.
- R10: On a return, arbitration in the same cycle compares against the restored level. An eligible request therefore shows on req_valid at the edge of the return itself (tail chaining).
- R11: A priority change to a pending line takes part in the next arbitration after the write, so the winner can change while requests stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request inputs, one per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | 5 | Line addressed by the write |
| cfg_field | input | 2 | Field select: 0 enable, 1 priority, 2 mode, 3 vector |
| cfg_data | input | 32 | Write data |
| cpu_ack | input | 1 | CPU accepts the presented request |
| cpu_ret | input | 1 | CPU finished the current handler |
| req_valid | output | 1 | A request is presented |
| req_line | output | 5 | Line number of the presented request |
| req_vector | output | 32 | Vector address of the presented request |
| cur_level | output | 4 | Running priority level, 8 when idle |

## Verification
A corrupt nesting stack shows up at the return strobe. On the edge of a return, cur_level shows the wrong restored value, and tail chaining either presents a request that should wait or fails to present one. A sticky pending bit that is lost or never cleared shows as a missing or repeated vector. This is seen one edge after the return or acknowledge that should reveal it. Arbitration faults are exposed within one edge, by offering tied, disabled and equal-priority requests together.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int N_LINES = 32;
    localparam int PRIO_W  = 3;
    localparam int VEC_W   = 32;
    localparam int LINE_W  = $clog2(N_LINES);
    localparam int LVL_W   = PRIO_W + 1;
    localparam int NEST    = 2 ** PRIO_W;
    localparam int DEPTH_W = $clog2(NEST + 1);
    localparam int SP_W    = $clog2(NEST);

    localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NEST);

    typedef enum logic [1:0] {
        FLD_ENABLE = 2'd0,
        FLD_PRIO   = 2'd1,
        FLD_MODE   = 2'd2,
        FLD_VECTOR = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic              en;
        logic              pulse;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } line_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } grant_t;

    function automatic logic more_urgent(input logic [PRIO_W-1:0] a,
                                         input logic [LVL_W-1:0]  lvl);
        return {1'b0, a} < lvl;
    endfunction

endpackage

// File: rtl/pvic_cfg.sv
module pvic_cfg
    import pvic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [LINE_W-1:0]          idx,
    input  cfg_field_e                 fld,
    input  logic [VEC_W-1:0]           data,
    output line_cfg_t [N_LINES-1:0]    cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            for (int i = 0; i < N_LINES; i++) begin
                if (idx == LINE_W'(i)) begin
                    case (fld)
                        FLD_ENABLE: cfg[i].en    <= data[0];
                        FLD_PRIO:   cfg[i].prio  <= data[PRIO_W-1:0];
                        FLD_MODE:   cfg[i].pulse <= data[0];
                        default:    cfg[i].vec   <= data;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pvic_pend.sv
module pvic_pend
    import pvic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_LINES-1:0]      irq_in,
    input  line_cfg_t [N_LINES-1:0] cfg,
    input  logic                    clr_valid,
    input  logic [LINE_W-1:0]       clr_line,
    output logic [N_LINES-1:0]      pend
);

    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] sticky_q;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] clr;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            rise[i] = irq_in[i] & ~prev_q[i];
            clr[i]  = clr_valid && (clr_line == LINE_W'(i));
            pend[i] = cfg[i].pulse ? (sticky_q[i] | rise[i]) : irq_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            sticky_q <= '0;
        end else begin
            prev_q <= irq_in;
            for (int i = 0; i < N_LINES; i++) begin
                sticky_q[i] <= cfg[i].pulse & ((sticky_q[i] & ~clr[i]) | rise[i]);
            end
        end
    end

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
    import pvic_pkg::*;
(
    input  line_cfg_t [N_LINES-1:0] cfg,
    input  logic [N_LINES-1:0]      pend,
    input  logic [LVL_W-1:0]        thresh,
    output grant_t                  grant
);

    always_comb begin
        grant = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (pend[i] && cfg[i].en && more_urgent(cfg[i].prio, thresh) &&
                (!grant.valid || (cfg[i].prio < grant.prio))) begin
                grant.valid = 1'b1;
                grant.line  = LINE_W'(i);
                grant.prio  = cfg[i].prio;
                grant.vec   = cfg[i].vec;
            end
        end
    end

endmodule

// File: rtl/pvic_nest.sv
module pvic_nest
    import pvic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [LVL_W-1:0]   push_lvl,
    input  logic               pop,
    output logic [LVL_W-1:0]   cur_level,
    output logic [LVL_W-1:0]   top_lvl,
    output logic [DEPTH_W-1:0] depth
);

    logic [LVL_W-1:0]   stk [NEST];
    logic [LVL_W-1:0]   cur_q;
    logic [DEPTH_W-1:0] depth_q;
    logic [SP_W-1:0]    top_idx;
    logic [SP_W-1:0]    push_idx;

    assign top_idx   = SP_W'(depth_q - 1'b1);
    assign push_idx  = SP_W'(depth_q);
    assign top_lvl   = (depth_q == '0) ? cur_q : stk[top_idx];
    assign cur_level = cur_q;
    assign depth     = depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= LVL_IDLE;
            depth_q <= '0;
            for (int k = 0; k < NEST; k++) stk[k] <= LVL_IDLE;
        end else if (push) begin
            stk[push_idx] <= cur_q;
            cur_q         <= push_lvl;
            depth_q       <= depth_q + 1'b1;
        end else if (pop && depth_q != '0) begin
            cur_q   <= stk[top_idx];
            depth_q <= depth_q - 1'b1;
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  irq_in,
    input  logic                cfg_we,
    input  logic [LINE_W-1:0]   cfg_line,
    input  logic [1:0]          cfg_field,
    input  logic [VEC_W-1:0]    cfg_data,
    input  logic                cpu_ack,
    input  logic                cpu_ret,
    output logic                req_valid,
    output logic [LINE_W-1:0]   req_line,
    output logic [VEC_W-1:0]    req_vector,
    output logic [LVL_W-1:0]    cur_level
);

    line_cfg_t [N_LINES-1:0] cfg;
    logic [N_LINES-1:0]      pend;
    grant_t                  grant;
    grant_t                  req_q;
    logic [LVL_W-1:0]        top_lvl;
    logic [LVL_W-1:0]        thresh;
    logic [DEPTH_W-1:0]      nest_depth;
    logic [PRIO_W-1:0]       req_prio_q;
    logic                    ack_fire;
    logic                    ret_fire;

    assign ack_fire   = cpu_ack && req_q.valid;
    assign ret_fire   = cpu_ret && !ack_fire && (nest_depth != '0);
    assign thresh     = ret_fire ? top_lvl : cur_level;
    assign req_prio_q = req_q.prio;

    pvic_cfg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .idx  (cfg_line),
        .fld  (cfg_field_e'(cfg_field)),
        .data (cfg_data),
        .cfg  (cfg)
    );

    pvic_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .cfg       (cfg),
        .clr_valid (ack_fire),
        .clr_line  (req_q.line),
        .pend      (pend)
    );

    pvic_arb u_arb (
        .cfg    (cfg),
        .pend   (pend),
        .thresh (thresh),
        .grant  (grant)
    );

    pvic_nest u_nest (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_fire),
        .push_lvl  ({1'b0, req_q.prio}),
        .pop       (ret_fire),
        .cur_level (cur_level),
        .top_lvl   (top_lvl),
        .depth     (nest_depth)
    );

    always_ff @(posedge clk) begin
        if (rst || ack_fire) req_q <= '0;
        else                 req_q <= grant;
    end

    assign req_valid  = req_q.valid;
    assign req_line   = req_q.line;
    assign req_vector = req_q.vec;

endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
    import pvic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cpu_ack,
    input logic               cpu_ret,
    input logic               req_valid,
    input logic [PRIO_W-1:0]  req_prio,
    input logic [LVL_W-1:0]   cur_level,
    input logic [DEPTH_W-1:0] depth
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!req_valid && cur_level == LVL_IDLE)); // R1

    AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cpu_ack) |=> !req_valid); // R7

    AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cpu_ack) |=> cur_level == {1'b0, $past(req_prio)}); // R7

    AST_ONLY_MORE_URGENT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ({1'b0, req_prio} < cur_level)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        depth <= DEPTH_W'(NEST)); // R9

    AST_IDLE_MATCHES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (depth == '0) == (cur_level == LVL_IDLE)); // R9

    AST_IDLE_RET_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_ret && !(req_valid && cpu_ack) && cur_level == LVL_IDLE)
        |=> cur_level == LVL_IDLE); // R9

endmodule

bind pvic_top pvic_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ack   (cpu_ack),
    .cpu_ret   (cpu_ret),
    .req_valid (req_valid),
    .req_prio  (req_prio_q),
    .cur_level (cur_level),
    .depth     (nest_depth)
);

// File: tb/tb_pvic_top.sv
`timescale 1ns/1ps
module tb_pvic_top;
    import pvic_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [N_LINES-1:0] irq_in;
    logic               cfg_we;
    logic [LINE_W-1:0]  cfg_line;
    logic [1:0]         cfg_field;
    logic [VEC_W-1:0]   cfg_data;
    logic               cpu_ack;
    logic               cpu_ret;
    logic               req_valid;
    logic [LINE_W-1:0]  req_line;
    logic [VEC_W-1:0]   req_vector;
    logic [LVL_W-1:0]   cur_level;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pvic_top dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
        .req_valid(req_valid), .req_line(req_line), .req_vector(req_vector),
        .cur_level(cur_level)
    );

    typedef struct packed {
        logic [31:0] irq;
        logic        ack;
        logic        ret;
        logic        valid;
        logic [4:0]  line;
        logic [3:0]  lvl;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t TBL [NROWS] = '{
        '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'd0,  4'd8},
        '{32'h0000_0008, 1'b0, 1'b0, 1'b1, 5'd3,  4'd8},
        '{32'h8000_0008, 1'b0, 1'b0, 1'b1, 5'd3,  4'd8},
        '{32'h8000_000A, 1'b0, 1'b0, 1'b1, 5'd3,  4'd8},
        '{32'h8000_000A, 1'b1, 1'b0, 1'b0, 5'd0,  4'd5},
        '{32'h8000_000A, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5},
        '{32'h8000_040A, 1'b0, 1'b0, 1'b1, 5'd10, 4'd5},
        '{32'h8000_040A, 1'b1, 1'b0, 1'b0, 5'd0,  4'd2},
        '{32'h8000_048A, 1'b0, 1'b0, 1'b0, 5'd0,  4'd2},
        '{32'h8000_040A, 1'b0, 1'b0, 1'b0, 5'd0,  4'd2},
        '{32'h8000_040A, 1'b0, 1'b1, 1'b1, 5'd7,  4'd5},
        '{32'h8000_040A, 1'b1, 1'b0, 1'b0, 5'd0,  4'd2},
        '{32'h8000_040A, 1'b0, 1'b1, 1'b1, 5'd10, 4'd5},
        '{32'h8000_000A, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5},
        '{32'h8000_000A, 1'b0, 1'b1, 1'b1, 5'd3,  4'd8},
        '{32'h8000_0000, 1'b0, 1'b0, 1'b1, 5'd31, 4'd8},
        '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'd0,  4'd8},
        '{32'h0000_0000, 1'b0, 1'b1, 1'b0, 5'd0,  4'd8},
        '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 5'd0,  4'd8}
    };

    function automatic string row_tag(input int r);
        case (r)
            2:       return "R3 tie";
            3:       return "R4 disabled";
            4, 7:    return "R7 ack";
            5, 8, 9: return "R8 no preempt";
            6:       return "R8 preempt";
            10:      return "R10 tail chain R6 sticky";
            12:      return "R9 restore R6 cleared";
            13:      return "R5 withdrawn";
            14:      return "R9 pop to idle";
            17:      return "R9 idle return";
            18:      return "R7 ack ignored";
            default: return "R3 select";
        endcase
    endfunction

    function automatic logic [31:0] vec_of(input int line);
        return 32'h1000_0000 + 32'(line) * 32'd16;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic v, input int line,
                              input logic [31:0] vec, input int lvl);
        check({tag, " valid"}, 32'(req_valid), 32'(v));
        check({tag, " level"}, 32'(cur_level), 32'(lvl));
        if (v) begin
            check({tag, " line"},   32'(req_line), 32'(line));
            check({tag, " vector"}, req_vector, vec);
        end
    endtask

    task automatic step(input logic [31:0] irq, input logic ack, input logic ret);
        irq_in  = irq;
        cpu_ack = ack;
        cpu_ret = ret;
        @(negedge clk);
        cpu_ack = 1'b0;
        cpu_ret = 1'b0;
    endtask

    task automatic cfg_write(input int line, input cfg_field_e fld, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_line  = LINE_W'(line);
        cfg_field = fld;
        cfg_data  = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic setup_line(input int line, input int prio, input logic pulse, input logic en);
        cfg_write(line, FLD_VECTOR, vec_of(line));
        cfg_write(line, FLD_PRIO, 32'(prio));
        cfg_write(line, FLD_MODE, {31'd0, pulse});
        cfg_write(line, FLD_ENABLE, {31'd0, en});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; irq_in = '1; cfg_we = 1'b0; cfg_line = '0; cfg_field = '0;
        cfg_data = '0; cpu_ack = 1'b0; cpu_ret = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 valid",  32'(req_valid), 32'd0);
        check("R1 level",  32'(cur_level), 32'd8);
        check("R1 line",   32'(req_line),  32'd0);
        check("R1 vector", req_vector,     32'd0);
        step('1, 1'b0, 1'b0);
        check("R1 lines disabled", 32'(req_valid), 32'd0);

        // R2: configuration of lines used below
        setup_line(3,  5, 1'b0, 1'b1);
        setup_line(31, 5, 1'b0, 1'b1);
        setup_line(10, 2, 1'b0, 1'b1);
        setup_line(7,  2, 1'b1, 1'b1);
        setup_line(20, 0, 1'b1, 1'b1);
        setup_line(1,  0, 1'b0, 1'b0);
        step('0, 1'b0, 1'b0);

        for (int r = 0; r < NROWS; r++) begin
            step(TBL[r].irq, TBL[r].ack, TBL[r].ret);
            expect_out($sformatf("row %0d %s", r, row_tag(r)), TBL[r].valid,
                       int'(TBL[r].line), vec_of(int'(TBL[r].line)), int'(TBL[r].lvl));
        end

        // R11: priority change while both lines are pending
        step(32'h8000_0008, 1'b0, 1'b0);
        expect_out("R11 before", 1'b1, 3, vec_of(3), 8);
        cfg_write(31, FLD_PRIO, 32'd1);
        expect_out("R11 write edge", 1'b1, 3, vec_of(3), 8);
        step(32'h8000_0008, 1'b0, 1'b0);
        expect_out("R11 after", 1'b1, 31, vec_of(31), 8);

        // R2: vector rewrite, then disable (R4)
        cfg_write(31, FLD_VECTOR, 32'hCAFE_0000);
        step(32'h8000_0008, 1'b0, 1'b0);
        expect_out("R2 new vector", 1'b1, 31, 32'hCAFE_0000, 8);
        cfg_write(31, FLD_ENABLE, 32'd0);
        step(32'h8000_0008, 1'b0, 1'b0);
        expect_out("R4 disabled winner", 1'b1, 3, vec_of(3), 8);
        step('0, 1'b0, 1'b0);
        expect_out("R5 idle", 1'b0, 0, 32'd0, 8);

        // R6: pulse re-armed by an edge in the acknowledge cycle
        step(32'h0010_0000, 1'b0, 1'b0);
        expect_out("R6 pulse", 1'b1, 20, vec_of(20), 8);
        step('0, 1'b0, 1'b0);
        expect_out("R6 sticky", 1'b1, 20, vec_of(20), 8);
        step(32'h0010_0000, 1'b1, 1'b0);
        expect_out("R7 ack pulse", 1'b0, 0, 32'd0, 0);
        step('0, 1'b0, 1'b0);
        expect_out("R8 equal waits", 1'b0, 0, 32'd0, 0);
        step('0, 1'b0, 1'b1);
        expect_out("R10 rearmed chain", 1'b1, 20, vec_of(20), 8);
        step('0, 1'b1, 1'b0);
        expect_out("R7 second ack", 1'b0, 0, 32'd0, 0);
        step('0, 1'b0, 1'b1);
        expect_out("R6 cleared", 1'b0, 0, 32'd0, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule